// File: doc/BRIEF.md
# Partition Label Generator

This block attaches a resource-partition label to each memory request that a processing element issues. The label has two parts: a partition identifier (PARTID), which shared resources use to apportion capacity, and a performance-monitoring group (PMG). The block takes a request strobe together with the privilege level of the requester (user or kernel) and the kind of access (instruction fetch or data access). It reads the two stored 64-bit label registers, one for each privilege level, and the hypervisor control bits. One clock later it presents the label with a valid flag.

The block works in three steps. First it picks the label register. A user request normally uses the user register. When the hypervisor has set the guest-application lock and the effective host-trap bit is clear, a user request uses the kernel register instead. Second, the enable bit of the chosen register decides whether the stored identifiers are used or the output falls back to the default identifiers. Third, when the hypervisor marks kernel-register PARTIDs as virtual, the PARTID is mapped to a physical value through a small table that can be written. The PMG is never mapped. An alternative-ID-space indicator taken from the kernel register goes out with every label.

Top module: `part_label_gen`

## Requirements
- R1: After reset, `lbl_valid`, `lbl_partid`, `lbl_pmg` and `lbl_alt` are all 0. Every translation-table entry reads as PARTID 0 until it is written.
- R2: `lbl_valid` is 1 in the cycle after a clock edge that samples `req_valid`=1, and 0 after any edge that samples `req_valid`=0. Between requests `lbl_partid` and `lbl_pmg` hold their values.
- R3: When bit 63 (enable) of the selected label register is 0, the label is the default PARTID 0 and the default PMG 0.
- R4: For an instruction fetch (`req_fetch`=1), the PARTID comes from register bits 15:0 and the PMG from bits 39:32.
- R5: For a data access (`req_fetch`=0), the PARTID comes from register bits 31:16 and the PMG from bits 47:40.
- R6: A user request (`req_kernel`=0) uses `kern_lbl_reg` when `guest_app_lock`=1 and `host_trap_gen`=0. In every other case it uses `user_lbl_reg`. A kernel request always uses `kern_lbl_reg`.
- R7: When `kern_vmap_en`=1 and the kernel register is selected, an enabled label's PARTID is the table entry indexed by the virtual PARTID if that PARTID is below 8, and 0 if it is 8 or more. The PMG is passed through unchanged.
- R8: The mapping of R7 also applies when a user request selects the kernel register under the lock of R6. PARTIDs read from `user_lbl_reg` are never mapped.
- R9: `lbl_alt` equals bit 54 of `kern_lbl_reg` as sampled with the request, whichever register is selected.
- R10: A clock edge with `tbl_wr_en`=1 stores `tbl_wr_data` in entry `tbl_wr_idx`. A request sampled at any later edge sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one per label |
| req_kernel | input | 1 | 1 = kernel-level requester, 0 = user-level requester |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data load/store |
| guest_app_lock | input | 1 | Hypervisor lock: user requests use the kernel register |
| host_trap_gen | input | 1 | Effective host-trap bit; when 1 it defeats the lock |
| kern_vmap_en | input | 1 | Kernel-register PARTIDs are virtual and are mapped |
| user_lbl_reg | input | 64 | Stored user-level label register |
| kern_lbl_reg | input | 64 | Stored kernel-level label register |
| tbl_wr_en | input | 1 | Translation-table write strobe |
| tbl_wr_idx | input | 3 | Translation-table entry index |
| tbl_wr_data | input | 16 | Physical PARTID to store |
| lbl_valid | output | 1 | Label valid, one cycle after a request |
| lbl_partid | output | 16 | Output partition identifier |
| lbl_pmg | output | 8 | Output monitoring group |
| lbl_alt | output | 1 | Alternative-ID-space indicator |

## Verification
The bench sweeps all 128 combinations of privilege level, access kind, lock, host-trap bit, mapping enable and the two enable bits. Each register is filled so that every field holds a distinct value, so the bench can see which register and which field reached the output. User-register PARTIDs are large values that never match a table entry, and kernel-register virtual PARTIDs span both in-range and out-of-range values. A mismatch therefore shows whether the register choice, the fetch/data field choice, the mapping, or the range check went wrong. The alternative-space bit has opposite values in the two registers, which shows whether it was taken from the wrong register. Separate sequences check the reset contents of the table and whether a table write is seen by the request that immediately follows it.

// File: rtl/plg_pkg.sv
package plg_pkg;
   localparam int REG_W       = 64;
   localparam int EN_BIT      = 63;
   localparam int ALT_BIT     = 54;
   localparam int PID_I_LSB   = 0;
   localparam int PID_D_LSB   = 16;
   localparam int PMG_I_LSB   = 32;
   localparam int PMG_D_LSB   = 40;
   localparam int PID_FIELD_W = 16;
   localparam int PMG_FIELD_W = 8;

   typedef enum logic {
      SRC_USER = 1'b0,
      SRC_KERN = 1'b1
   } src_e;
endpackage

// File: rtl/plg_src_select.sv
module plg_src_select
   import plg_pkg::*;
#(
   parameter int PARTID_W = 16,
   parameter int PMG_W    = 8
) (
   input  logic                req_kernel,
   input  logic                req_fetch,
   input  logic                guest_app_lock,
   input  logic                host_trap_gen,
   input  logic [REG_W-1:0]    user_lbl_reg,
   input  logic [REG_W-1:0]    kern_lbl_reg,
   output src_e                src,
   output logic                sel_en,
   output logic [PARTID_W-1:0] raw_partid,
   output logic [PMG_W-1:0]    raw_pmg,
   output logic                alt_space
);
   logic [REG_W-1:0] sel_reg;

   always_comb begin
      if (req_kernel || (guest_app_lock && !host_trap_gen)) src = SRC_KERN;
      else                                                  src = SRC_USER;
   end

   assign sel_reg = (src == SRC_KERN) ? kern_lbl_reg : user_lbl_reg;
   assign sel_en  = sel_reg[EN_BIT];

   always_comb begin
      if (req_fetch) begin
         raw_partid = sel_reg[PID_I_LSB +: PARTID_W];
         raw_pmg    = sel_reg[PMG_I_LSB +: PMG_W];
      end else begin
         raw_partid = sel_reg[PID_D_LSB +: PARTID_W];
         raw_pmg    = sel_reg[PMG_D_LSB +: PMG_W];
      end
   end

   // one space choice governs both registers: it lives in the kernel one
   assign alt_space = kern_lbl_reg[ALT_BIT];
endmodule

// File: rtl/plg_xlat_table.sv
module plg_xlat_table #(
   parameter int PARTID_W = 16,
   parameter int DEPTH    = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] wr_idx,
   input  logic [PARTID_W-1:0]      wr_data,
   input  logic [PARTID_W-1:0]      vid,
   output logic [PARTID_W-1:0]      pid
);
   localparam int IDX_W = $clog2(DEPTH);

   logic [DEPTH-1:0][PARTID_W-1:0] entry_q;
   logic                           in_range;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         entry_q <= '0;
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (wr_en && (wr_idx == IDX_W'(e))) entry_q[e] <= wr_data;
         end
      end
   end

   generate
      if (PARTID_W > IDX_W) begin : g_range_chk
         assign in_range = (vid[PARTID_W-1:IDX_W] == '0);
      end else begin : g_full_cover
         assign in_range = 1'b1;
      end
   endgenerate

   assign pid = in_range ? entry_q[vid[IDX_W-1:0]] : '0;
endmodule

// File: rtl/plg_label_reg.sv
module plg_label_reg #(
   parameter int PARTID_W = 16,
   parameter int PMG_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap,
   input  logic [PARTID_W-1:0] partid_in,
   input  logic [PMG_W-1:0]    pmg_in,
   input  logic                alt_in,
   output logic                valid_q,
   output logic [PARTID_W-1:0] partid_q,
   output logic [PMG_W-1:0]    pmg_q,
   output logic                alt_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         partid_q <= '0;
         pmg_q    <= '0;
         alt_q    <= 1'b0;
      end else begin
         valid_q <= cap;
         if (cap) begin
            partid_q <= partid_in;
            pmg_q    <= pmg_in;
            alt_q    <= alt_in;
         end
      end
   end
endmodule

// File: rtl/part_label_gen.sv
module part_label_gen
   import plg_pkg::*;
#(
   parameter int PARTID_W   = 16,
   parameter int PMG_W      = 8,
   parameter int XLAT_DEPTH = 8,
   parameter bit HAS_VMAP   = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic                          req_kernel,
   input  logic                          req_fetch,
   input  logic                          guest_app_lock,
   input  logic                          host_trap_gen,
   input  logic                          kern_vmap_en,
   input  logic [63:0]                   user_lbl_reg,
   input  logic [63:0]                   kern_lbl_reg,
   input  logic                          tbl_wr_en,
   input  logic [$clog2(XLAT_DEPTH)-1:0] tbl_wr_idx,
   input  logic [PARTID_W-1:0]           tbl_wr_data,
   output logic                          lbl_valid,
   output logic [PARTID_W-1:0]           lbl_partid,
   output logic [PMG_W-1:0]              lbl_pmg,
   output logic                          lbl_alt
);
   localparam int IDX_W          = $clog2(XLAT_DEPTH);
   localparam logic [PARTID_W-1:0] DEF_PARTID = '0;
   localparam logic [PMG_W-1:0]    DEF_PMG    = '0;

   generate
      if (PARTID_W < 1 || PARTID_W > PID_FIELD_W) begin : g_bad_pid_w
         $error("PARTID_W must be 1..16");
      end
      if (PMG_W < 1 || PMG_W > PMG_FIELD_W) begin : g_bad_pmg_w
         $error("PMG_W must be 1..8");
      end
      if (XLAT_DEPTH < 2 || (1 << IDX_W) != XLAT_DEPTH) begin : g_bad_depth
         $error("XLAT_DEPTH must be a power of two of at least 2");
      end
      if (IDX_W > PARTID_W) begin : g_bad_idx
         $error("XLAT_DEPTH exceeds the PARTID space");
      end
   endgenerate

   src_e                src;
   logic                sel_en;
   logic [PARTID_W-1:0] raw_partid;
   logic [PMG_W-1:0]    raw_pmg;
   logic                alt_space;
   logic [PARTID_W-1:0] phys_partid;
   logic [PARTID_W-1:0] next_partid;
   logic [PMG_W-1:0]    next_pmg;

   plg_src_select #(.PARTID_W(PARTID_W), .PMG_W(PMG_W)) src_sel_i (
      .req_kernel     (req_kernel),
      .req_fetch      (req_fetch),
      .guest_app_lock (guest_app_lock),
      .host_trap_gen  (host_trap_gen),
      .user_lbl_reg   (user_lbl_reg),
      .kern_lbl_reg   (kern_lbl_reg),
      .src            (src),
      .sel_en         (sel_en),
      .raw_partid     (raw_partid),
      .raw_pmg        (raw_pmg),
      .alt_space      (alt_space)
   );

   generate
      if (HAS_VMAP) begin : g_vmap
         logic [PARTID_W-1:0] tbl_pid;
         plg_xlat_table #(.PARTID_W(PARTID_W), .DEPTH(XLAT_DEPTH)) xlat_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (tbl_wr_en),
            .wr_idx  (tbl_wr_idx),
            .wr_data (tbl_wr_data),
            .vid     (raw_partid),
            .pid     (tbl_pid)
         );
         assign phys_partid = (kern_vmap_en && src == SRC_KERN) ? tbl_pid : raw_partid;
      end else begin : g_no_vmap
         assign phys_partid = raw_partid;
      end
   endgenerate

   assign next_partid = sel_en ? phys_partid : DEF_PARTID;
   assign next_pmg    = sel_en ? raw_pmg     : DEF_PMG;

   plg_label_reg #(.PARTID_W(PARTID_W), .PMG_W(PMG_W)) out_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap       (req_valid),
      .partid_in (next_partid),
      .pmg_in    (next_pmg),
      .alt_in    (alt_space),
      .valid_q   (lbl_valid),
      .partid_q  (lbl_partid),
      .pmg_q     (lbl_pmg),
      .alt_q     (lbl_alt)
   );
endmodule

// File: rtl/plg_label_chk.sv
module plg_label_chk #(
   parameter int PARTID_W   = 16,
   parameter int PMG_W      = 8,
   parameter int XLAT_DEPTH = 8,
   parameter bit HAS_VMAP   = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_kernel,
   input logic                req_fetch,
   input logic                guest_app_lock,
   input logic                host_trap_gen,
   input logic                kern_vmap_en,
   input logic [63:0]         user_lbl_reg,
   input logic [63:0]         kern_lbl_reg,
   input logic                lbl_valid,
   input logic [PARTID_W-1:0] lbl_partid,
   input logic [PMG_W-1:0]    lbl_pmg,
   input logic                lbl_alt
);
   logic use_kern;
   logic en_sel;
   assign use_kern = req_kernel || (guest_app_lock && !host_trap_gen);
   assign en_sel   = use_kern ? kern_lbl_reg[63] : user_lbl_reg[63];

   // R2
   valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> lbl_valid);
   // R2
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !lbl_valid);
   // R2
   label_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(lbl_partid) && $stable(lbl_pmg)));
   // R3
   disabled_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !en_sel) |=> (lbl_partid == '0 && lbl_pmg == '0));
   // R9
   alt_from_kern_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (lbl_alt == $past(kern_lbl_reg[54])));
   // R4
   fetch_user_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !use_kern && user_lbl_reg[63] && req_fetch) |=>
      (lbl_partid == $past(user_lbl_reg[PARTID_W-1:0]) &&
       lbl_pmg == $past(user_lbl_reg[32 +: PMG_W])));
   // R7
   vmap_out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_VMAP && req_valid && req_kernel && kern_vmap_en && kern_lbl_reg[63] &&
       !req_fetch && (kern_lbl_reg[16 +: PARTID_W] >= XLAT_DEPTH)) |=>
      (lbl_partid == '0));
endmodule

bind part_label_gen plg_label_chk #(
   .PARTID_W(PARTID_W), .PMG_W(PMG_W), .XLAT_DEPTH(XLAT_DEPTH), .HAS_VMAP(HAS_VMAP)
) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_kernel     (req_kernel),
   .req_fetch      (req_fetch),
   .guest_app_lock (guest_app_lock),
   .host_trap_gen  (host_trap_gen),
   .kern_vmap_en   (kern_vmap_en),
   .user_lbl_reg   (user_lbl_reg),
   .kern_lbl_reg   (kern_lbl_reg),
   .lbl_valid      (lbl_valid),
   .lbl_partid     (lbl_partid),
   .lbl_pmg        (lbl_pmg),
   .lbl_alt        (lbl_alt)
);

// File: tb/part_label_gen_tb_top.sv
module part_label_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_kernel, req_fetch, guest_app_lock, host_trap_gen, kern_vmap_en;
   logic [63:0] user_lbl_reg, kern_lbl_reg;
   logic        tbl_wr_en;
   logic [2:0]  tbl_wr_idx;
   logic [15:0] tbl_wr_data;
   logic        lbl_valid, lbl_alt;
   logic [15:0] lbl_partid;
   logic [7:0]  lbl_pmg;

   int total = 0;
   int bad   = 0;
   logic [15:0] tbl_m [8];

   always #4 clk = ~clk;

   part_label_gen dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kernel(req_kernel),
      .req_fetch(req_fetch), .guest_app_lock(guest_app_lock), .host_trap_gen(host_trap_gen),
      .kern_vmap_en(kern_vmap_en), .user_lbl_reg(user_lbl_reg), .kern_lbl_reg(kern_lbl_reg),
      .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data),
      .lbl_valid(lbl_valid), .lbl_partid(lbl_partid), .lbl_pmg(lbl_pmg), .lbl_alt(lbl_alt)
   );

   task automatic check(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] mk(input logic en, input logic alt, input logic [7:0] pmgd,
                                      input logic [7:0] pmgi, input logic [15:0] pidd,
                                      input logic [15:0] pidi);
      logic [63:0] r = '0;
      r[63] = en; r[54] = alt; r[47:40] = pmgd; r[39:32] = pmgi;
      r[31:16] = pidd; r[15:0] = pidi;
      return r;
   endfunction

   task automatic tbl_write(input int idx, input logic [15:0] val);
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_idx = 3'(idx); tbl_wr_data = val;
      @(negedge clk);
      tbl_wr_en = 1'b0;
      tbl_m[idx] = val;
   endtask

   task automatic do_req(input logic kern, input logic fetch, input logic lock,
                         input logic tge, input logic vmap, input logic [63:0] u,
                         input logic [63:0] k, input bit hold_chk);
      logic        use1, en;
      logic [63:0] r;
      logic [15:0] vp, ep;
      logic [7:0]  em;
      string       tag;
      @(negedge clk);
      req_kernel = kern; req_fetch = fetch; guest_app_lock = lock; host_trap_gen = tge;
      kern_vmap_en = vmap; user_lbl_reg = u; kern_lbl_reg = k; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      use1 = kern || (lock && !tge);
      r    = use1 ? k : u;
      en   = r[63];
      vp   = fetch ? r[15:0] : r[31:16];
      em   = fetch ? r[39:32] : r[47:40];
      ep   = vp;
      if (use1 && vmap) ep = (vp < 16'd8) ? tbl_m[vp[2:0]] : 16'd0;
      if (!en) begin ep = 16'd0; em = 8'd0; end
      if (!en)                    tag = "R3";
      else if (use1 && vmap)      tag = kern ? "R7" : "R8";
      else if (!kern && use1)     tag = "R6";
      else                        tag = fetch ? "R4" : "R5";
      check("R2", "valid", 32'(lbl_valid), 32'd1);
      check(tag, "partid", 32'(lbl_partid), 32'(ep));
      check(tag, "pmg", 32'(lbl_pmg), 32'(em));
      check("R9", "alt", 32'(lbl_alt), 32'(k[54]));
      if (hold_chk) begin
         user_lbl_reg = ~u; kern_lbl_reg = ~k;
         @(negedge clk);
         check("R2", "valid idle", 32'(lbl_valid), 32'd0);
         check("R2", "partid hold", 32'(lbl_partid), 32'(ep));
         check("R2", "pmg hold", 32'(lbl_pmg), 32'(em));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL R2 watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_kernel = 1'b0; req_fetch = 1'b0;
      guest_app_lock = 1'b0; host_trap_gen = 1'b0; kern_vmap_en = 1'b0;
      user_lbl_reg = '0; kern_lbl_reg = '0;
      tbl_wr_en = 1'b0; tbl_wr_idx = '0; tbl_wr_data = '0;
      for (int i = 0; i < 8; i++) tbl_m[i] = 16'd0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "valid", 32'(lbl_valid), 32'd0);
      check("R1", "partid", 32'(lbl_partid), 32'd0);
      check("R1", "pmg", 32'(lbl_pmg), 32'd0);
      check("R1", "alt", 32'(lbl_alt), 32'd0);
      rst_n = 1'b1;
      // R1 table reads 0 before any write
      do_req(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '0,
             mk(1'b1, 1'b0, 8'h5A, 8'h11, 16'd5, 16'd2), 1'b0);
      check("R1", "table reset", 32'(lbl_partid), 32'd0);

      for (int i = 0; i < 8; i++) tbl_write(i, 16'h0A01 + 16'(i * 16'h0111));

      // R10 a write is seen by the very next request
      tbl_write(3, 16'hBEEF);
      do_req(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '0,
             mk(1'b1, 1'b1, 8'h01, 8'h02, 16'd0, 16'd3), 1'b0);
      check("R10", "new entry", 32'(lbl_partid), 32'hBEEF);

      for (int c = 0; c < 128; c++) begin
         logic [63:0] u, k;
         logic [6:0]  b;
         b = 7'(c);
         k = mk(b[6], b[0] ^ b[3], 8'h40 + 8'(c), 8'h80 + 8'(c),
                16'((c * 5) % 11), 16'(c % 12));
         u = mk(b[5], ~(b[0] ^ b[3]), 8'hC0 ^ 8'(c), 8'h20 + 8'(c),
                16'h2000 + 16'(c), 16'h1000 + 16'(c));
         do_req(b[0], b[1], b[2], b[3], b[4], u, k, (c % 16) == 7);
         if (c == 63) tbl_write(c % 8, 16'h7700 + 16'(c));
      end

      // R8 user register is never mapped even when its PARTID is in table range
      do_req(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, mk(1'b1, 1'b0, 8'h33, 8'h44, 16'd6, 16'd1),
             mk(1'b1, 1'b0, 8'h0, 8'h0, 16'd2, 16'd2), 1'b0);
      check("R8", "user unmapped", 32'(lbl_partid), 32'd6);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule